// File: doc/BRIEF.md
# Hamming 12-bit SEC Link

This block carries 8-bit data words from an I/O controller to a memory-side receiver over a 12-bit bus, and corrects any single flipped bit on the way. On the transmit side, four even-parity check bits are computed from the byte. They are woven into the byte to form a 12-bit codeword, which is registered onto the bus.

On the receive side, the 12 bus bits are checked again to give a 4-bit syndrome. The syndrome drives a 4-to-16 one-hot decoder. Channel 0 of the decoder means a clean word. Channels 1 to 12 form an error vector that lines up with the codeword positions. Only the eight data positions of that vector are XORed into the received bits, which gives the corrected byte.

The receiver also returns the raw syndrome and three status flags:
- any error seen;
- the error sits in a check bit;
- the syndrome points outside the codeword.

The transmit and receive halves each register their results. Each half therefore has one cycle of latency from its valid input to its valid output, and the bus between them can be tapped or disturbed.

Top module: `hamming12_link`

## Requirements
- R1: Bit i of `cw_bus` carries codeword position i+1. From position 1 to position 12 the order is P1 P2 D1 P3 D2 D3 D4 P4 D5 D6 D7 D8, where `tx_data[k]` is D(k+1). For example, byte 0x01 encodes to 0x007 and byte 0x80 encodes to 0x888.
- R2: Each check bit at position 2^b is chosen so that the XOR of all codeword positions whose 1-based index has bit b set is zero (even parity).
- R3: `cw_valid` equals `tx_valid` from one clock earlier. `cw_bus` loads the encoded word one clock after `tx_valid` is high, and holds its value while `tx_valid` is low.
- R4: `out_syndrome[b]` is the XOR of the received positions whose index has bit b set. Bit 3 is the MSB, so a lone flip at position p gives a syndrome of p.
- R5: A received word with a zero syndrome gives `out_err`=0, `out_chk_err`=0 and `out_uncorr`=0. `out_data` equals the data bits as received.
- R6: A single flip at any data position (3, 5, 6, 7, 9, 10, 11 or 12) is corrected. `out_data` returns the original byte, `out_err`=1 and `out_chk_err`=0.
- R7: A single flip at a check position (1, 2, 4 or 8) gives `out_err`=1 and `out_chk_err`=1, and `out_data` equals the original byte.
- R8: A syndrome of 13, 14 or 15 gives `out_uncorr`=1 and `out_err`=1, with `out_chk_err`=0. `out_data` then equals the received data bits unchanged.
- R9: `out_valid` equals `rx_valid` from one clock earlier. The other receive outputs load one clock after `rx_valid` is high and hold their values while it is low.
- R10: While `rst` is high at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit byte present |
| tx_data | input | 8 | Byte to encode, bit k is D(k+1) |
| cw_valid | output | 1 | Codeword on bus is valid |
| cw_bus | output | 12 | Registered 12-bit codeword, bit i is position i+1 |
| rx_valid | input | 1 | Received codeword present |
| rx_code | input | 12 | Received 12-bit codeword |
| out_valid | output | 1 | Receive results valid |
| out_data | output | 8 | Corrected byte |
| out_syndrome | output | 4 | Raw syndrome |
| out_err | output | 1 | Syndrome nonzero |
| out_chk_err | output | 1 | Error lies in a check position |
| out_uncorr | output | 1 | Syndrome points beyond position 12 |

## Verification
The codeword is due on `cw_bus` after exactly one rising edge following `tx_valid`. The corrected byte, syndrome and flags are due after exactly one rising edge following `rx_valid`. The bench changes inputs on a falling edge and reads results on the next falling edge, so every sample falls after the single register stage and before the next one. The hold checks first drive new inputs with valid low. They then read the outputs one falling edge later, after an edge that must not have loaded anything.

// File: rtl/hamming12_pkg.sv
package hamming12_pkg;

    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int SYN_W  = CHK_W;
    localparam int DEC_W  = 1 << SYN_W;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SYN_W-1:0]  syn_t;
    typedef logic [CHK_W-1:0]  chk_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_DATA    = 2'd1,
        ERR_CHECK   = 2'd2,
        ERR_OUTSIDE = 2'd3
    } err_class_e;

    typedef struct packed {
        data_t      data;
        syn_t       syn;
        err_class_e cls;
    } rx_word_t;

    // position index p (1-based) holds a check bit when it is a power of two
    function automatic logic is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // which check bit lives at power-of-two position p
    function automatic int chk_idx(input int p);
        int r;
        r = 0;
        for (int b = 0; b < CHK_W; b++) begin
            if ((1 << b) == p) r = b;
        end
        return r;
    endfunction

    // data bit index stored at non-power-of-two position p
    function automatic int pos_data_idx(input int p);
        int cnt;
        cnt = 0;
        for (int q = 1; q <= p; q++) begin
            if (is_pow2(q)) cnt++;
        end
        return p - 1 - cnt;
    endfunction

    // 1-based position of data bit k
    function automatic int data_pos(input int k);
        int cnt;
        int r;
        cnt = 0;
        r   = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == k) r = p;
                cnt++;
            end
        end
        return r;
    endfunction

    // positions whose index has bit b set
    function automatic code_t group_mask(input int b);
        code_t m;
        m = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            m[p-1] = ((p >> b) & 1) != 0;
        end
        return m;
    endfunction

    // positions that carry check bits
    function automatic code_t check_mask();
        code_t m;
        m = '0;
        for (int p = 1; p <= CODE_W; p++) begin
            m[p-1] = is_pow2(p);
        end
        return m;
    endfunction

    function automatic syn_t calc_syndrome(input code_t c);
        syn_t s;
        for (int b = 0; b < SYN_W; b++) begin
            s[b] = ^(c & group_mask(b));
        end
        return s;
    endfunction

    function automatic data_t extract_data(input code_t c);
        data_t d;
        for (int k = 0; k < DATA_W; k++) begin
            d[k] = c[data_pos(k) - 1];
        end
        return d;
    endfunction

endpackage

// File: rtl/h12_encoder.sv
module h12_encoder
    import hamming12_pkg::*;
(
    input  data_t data,
    output code_t code
);

    code_t placed;
    chk_t  chk;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        if (is_pow2(p)) begin : g_chk
            assign placed[p-1] = 1'b0;
            assign code[p-1]   = chk[chk_idx(p)];
        end else begin : g_dat
            assign placed[p-1] = data[pos_data_idx(p)];
            assign code[p-1]   = placed[p-1];
        end
    end

    for (genvar b = 0; b < CHK_W; b++) begin : g_par
        assign chk[b] = ^(placed & group_mask(b));
    end

endmodule

// File: rtl/h12_syndrome.sv
module h12_syndrome
    import hamming12_pkg::*;
(
    input  code_t code,
    output syn_t  syn
);

    for (genvar b = 0; b < SYN_W; b++) begin : g_syn
        assign syn[b] = ^(code & group_mask(b));
    end

endmodule

// File: rtl/h12_onehot_dec.sv
module h12_onehot_dec
    import hamming12_pkg::*;
(
    input  syn_t             syn,
    output logic             clean,
    output code_t            err_vec,
    output logic             beyond
);

    logic [DEC_W-1:0] chan;

    always_comb begin
        chan      = '0;
        chan[syn] = 1'b1;
    end

    assign clean   = chan[0];
    assign err_vec = chan[CODE_W:1];
    assign beyond  = |chan[DEC_W-1:CODE_W+1];

endmodule

// File: rtl/h12_corrector.sv
module h12_corrector
    import hamming12_pkg::*;
(
    input  code_t    code,
    input  syn_t     syn,
    input  logic     clean,
    input  code_t    err_vec,
    input  logic     beyond,
    output rx_word_t res
);

    localparam code_t CHK_POS = check_mask();

    data_t      fixed;
    err_class_e cls;

    for (genvar k = 0; k < DATA_W; k++) begin : g_fix
        assign fixed[k] = code[data_pos(k) - 1] ^ err_vec[data_pos(k) - 1];
    end

    always_comb begin
        if (clean)                      cls = ERR_NONE;
        else if (beyond)                cls = ERR_OUTSIDE;
        else if (|(err_vec & CHK_POS))  cls = ERR_CHECK;
        else                            cls = ERR_DATA;
    end

    assign res.data = fixed;
    assign res.syn  = syn;
    assign res.cls  = cls;

endmodule

// File: rtl/hamming12_link.sv
module hamming12_link
    import hamming12_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              cw_valid,
    output logic [CODE_W-1:0] cw_bus,
    input  logic              rx_valid,
    input  logic [CODE_W-1:0] rx_code,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [SYN_W-1:0]  out_syndrome,
    output logic              out_err,
    output logic              out_chk_err,
    output logic              out_uncorr
);

    code_t    enc_code;
    syn_t     syn;
    logic     clean;
    code_t    err_vec;
    logic     beyond;
    rx_word_t res_d;
    rx_word_t res_q;
    logic     vld_q;

    h12_encoder u_enc (
        .data (tx_data),
        .code (enc_code)
    );

    h12_syndrome u_syn (
        .code (rx_code),
        .syn  (syn)
    );

    h12_onehot_dec u_dec (
        .syn     (syn),
        .clean   (clean),
        .err_vec (err_vec),
        .beyond  (beyond)
    );

    h12_corrector u_fix (
        .code    (rx_code),
        .syn     (syn),
        .clean   (clean),
        .err_vec (err_vec),
        .beyond  (beyond),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cw_valid <= 1'b0;
            cw_bus   <= '0;
        end else begin
            cw_valid <= tx_valid;
            if (tx_valid) cw_bus <= enc_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '{data: '0, syn: '0, cls: ERR_NONE};
        end else begin
            vld_q <= rx_valid;
            if (rx_valid) res_q <= res_d;
        end
    end

    assign out_valid    = vld_q;
    assign out_data     = res_q.data;
    assign out_syndrome = res_q.syn;
    assign out_err      = (res_q.cls != ERR_NONE);
    assign out_chk_err  = (res_q.cls == ERR_CHECK);
    assign out_uncorr   = (res_q.cls == ERR_OUTSIDE);

endmodule

// File: rtl/h12_link_checker.sv
module h12_link_checker
    import hamming12_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tx_valid,
    input logic [DATA_W-1:0] tx_data,
    input logic              cw_valid,
    input logic [CODE_W-1:0] cw_bus,
    input logic              rx_valid,
    input logic [CODE_W-1:0] rx_code,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic [SYN_W-1:0]  out_syndrome,
    input logic              out_err,
    input logic              out_chk_err,
    input logic              out_uncorr
);

    a_r3_cw_valid_rise: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> cw_valid);
    a_r3_cw_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> !cw_valid);
    a_r3_cw_hold: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> $stable(cw_bus));
    a_r2_even_parity: assert property (@(posedge clk) disable iff (rst)
        cw_valid |-> (calc_syndrome(cw_bus) == '0));
    a_r9_out_valid_rise: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> out_valid);
    a_r9_out_valid_fall: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> !out_valid);
    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> ($stable(out_data) && $stable(out_syndrome)));
    a_r4_syndrome: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> (out_syndrome == $past(calc_syndrome(rx_code))));
    a_r5_clean_pass: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && calc_syndrome(rx_code) == '0)
            |=> (!out_err && out_data == $past(extract_data(rx_code))));
    a_r7_check_flag: assert property (@(posedge clk) disable iff (rst)
        out_chk_err |-> (out_err && !out_uncorr));
    a_r8_outside: assert property (@(posedge clk) disable iff (rst)
        out_uncorr |-> (out_err && out_syndrome > SYN_W'(CODE_W)));

endmodule

bind hamming12_link h12_link_checker u_chk (.*);

// File: tb/tb_hamming12_link.sv
`timescale 1ns/1ps
module tb_hamming12_link;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        cw_valid;
    logic [11:0] cw_bus;
    logic        rx_valid = 1'b0;
    logic [11:0] rx_code = '0;
    logic        out_valid;
    logic [7:0]  out_data;
    logic [3:0]  out_syndrome;
    logic        out_err;
    logic        out_chk_err;
    logic        out_uncorr;

    int n_total = 0;
    int n_bad   = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    hamming12_link dut (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .cw_valid(cw_valid), .cw_bus(cw_bus),
        .rx_valid(rx_valid), .rx_code(rx_code),
        .out_valid(out_valid), .out_data(out_data),
        .out_syndrome(out_syndrome), .out_err(out_err),
        .out_chk_err(out_chk_err), .out_uncorr(out_uncorr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // independent model: data positions listed by hand
    function automatic logic [11:0] m_encode(input logic [7:0] d);
        int dpos[8] = '{3, 5, 6, 7, 9, 10, 11, 12};
        logic [11:0] c;
        logic x;
        c = '0;
        for (int k = 0; k < 8; k++) c[dpos[k]-1] = d[k];
        for (int b = 0; b < 4; b++) begin
            x = 1'b0;
            for (int p = 1; p <= 12; p++) if (p[b]) x ^= c[p-1];
            c[(1 << b) - 1] = x;
        end
        return c;
    endfunction

    function automatic logic [7:0] m_data(input logic [11:0] c);
        return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
    endfunction

    task automatic send_tx(input logic [7:0] d);
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic send_rx(input logic [11:0] c);
        @(negedge clk);
        rx_code  = c;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R10 cw_valid", 32'(cw_valid), 0);
        check("R10 cw_bus", 32'(cw_bus), 0);
        check("R10 out_valid", 32'(out_valid), 0);
        check("R10 out_data", 32'(out_data), 0);
        check("R10 flags", 32'({out_syndrome, out_err, out_chk_err, out_uncorr}), 0);
        rst = 1'b0;
    endtask

    task automatic t_layout;
        send_tx(8'h01);
        check("R1 byte01", 32'(cw_bus), 32'h007);
        check("R3 cw_valid", 32'(cw_valid), 1);
        send_tx(8'h80);
        check("R1 byte80", 32'(cw_bus), 32'h888);
    endtask

    task automatic t_tx_hold;
        send_tx(8'h5A);
        @(negedge clk);
        tx_data = 8'hA5;
        @(negedge clk);
        check("R3 hold cw_valid", 32'(cw_valid), 0);
        check("R3 hold cw_bus", 32'(cw_bus), 32'(m_encode(8'h5A)));
    endtask

    task automatic t_sweep;
        for (int d = 0; d < 256; d++) begin
            logic [11:0] cw;
            send_tx(8'(d));
            cw = cw_bus;
            check("R1 R2 encode", 32'(cw), 32'(m_encode(8'(d))));
            for (int f = 0; f <= 12; f++) begin
                logic [11:0] m;
                bit is_chk;
                m = (f == 0) ? 12'h000 : (12'h001 << (f - 1));
                is_chk = (f == 1) || (f == 2) || (f == 4) || (f == 8);
                send_rx(cw ^ m);
                check("R9 out_valid", 32'(out_valid), 1);
                check("R4 syndrome", 32'(out_syndrome), 32'(f));
                if (f == 0) begin
                    check("R5 data", 32'(out_data), 32'(d));
                    check("R5 flags", 32'({out_err, out_chk_err, out_uncorr}), 0);
                end else if (is_chk) begin
                    check("R7 data", 32'(out_data), 32'(d));
                    check("R7 flags", 32'({out_err, out_chk_err, out_uncorr}), 32'b110);
                end else begin
                    check("R6 data", 32'(out_data), 32'(d));
                    check("R6 flags", 32'({out_err, out_chk_err, out_uncorr}), 32'b100);
                end
            end
        end
    endtask

    task automatic t_outside;
        logic [7:0] bytes[3] = '{8'h00, 8'h3C, 8'hFF};
        for (int i = 0; i < 3; i++) begin
            for (int j = 1; j <= 3; j++) begin
                logic [11:0] rc;
                rc = m_encode(bytes[i]) ^ 12'h800 ^ (12'h001 << (j - 1));
                send_rx(rc);
                check("R8 syndrome", 32'(out_syndrome), 32'(12 + j));
                check("R8 flags", 32'({out_err, out_chk_err, out_uncorr}), 32'b101);
                check("R8 data", 32'(out_data), 32'(m_data(rc)));
            end
        end
    endtask

    task automatic t_rx_hold;
        send_rx(m_encode(8'hC3) ^ 12'h010);
        @(negedge clk);
        rx_code = m_encode(8'h11) ^ 12'h800;
        @(negedge clk);
        check("R9 hold valid", 32'(out_valid), 0);
        check("R9 hold data", 32'(out_data), 32'hC3);
        check("R9 hold syndrome", 32'(out_syndrome), 5);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_layout();
        t_tx_hold();
        t_sweep();
        t_outside();
        t_rx_hold();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

endmodule